// File: doc/BRIEF.md
# Three-Channel Thermal Limit Monitor

This block is the digital half of a board-level temperature supervisor. Three converters deliver signed whole-degree Celsius samples, each on its own bus with a one-cycle strobe and an open-sensor indication. Each channel keeps its last accepted reading and three signed limits: low, high and critical. It also keeps sticky warning flags that record every sample that reached a limit. Software reaches all of this through a 16-byte register window. A channel-select register decides which channel's status, reading and limit registers appear at the banked offsets.

Warning flags stay set after the temperature returns to normal. Software re-arms them by writing ones, and any flag whose condition still holds sets again on the next accepted sample. A dedicated alarm pin stays high while any channel holds its critical flag. Because the pin follows the sticky flag and not the live comparison, it drops only when software acknowledges the event.

Every channel runs a four-state machine. CH_DISABLED moves to CH_ACTIVE when the enable bit is set. CH_ACTIVE moves to CH_OPEN when a strobe arrives with the open-sensor input high. CH_OPEN moves back to CH_ACTIVE after the next strobe that arrives with that input low. Any state moves to CH_HALT while the global standby bit is set. When standby is released, the channel returns to CH_DISABLED, CH_OPEN or CH_ACTIVE according to its enable bit and its open-sensor flag. From CH_ACTIVE or CH_OPEN, clearing the enable bit leads to CH_DISABLED. The state register follows the control bits one clock later. A strobe is accepted only while the state register holds CH_ACTIVE or CH_OPEN.

Top module: `tmon_thermal_monitor`

## Requirements
- R1: After reset, standby (offset 0x8 bit 0) reads 0, select (0x9) reads 0, every channel's status (0xA) reads 0x00 and its reading (0xB) reads 0x00, the high (0xC) and critical (0xE) limits read 0x7F, the low limit (0xD) reads 0x80, and the alarm pin is low.
- R2: Writing 0, 1 or 2 to offset 0x9 selects the channel whose registers appear at 0xA–0xE. A write of 3 or more leaves the selection unchanged. Limit writes affect only the selected channel.
- R3: Status bit 0 is the channel enable and can be read and written. A strobe changes neither the reading nor any flag of a disabled channel.
- R4: On an accepted clean sample, status bit 1 sets when the sample is at or below the low limit, compared as signed 8-bit values.
- R5: On an accepted clean sample, status bit 2 sets when the sample is at or above the high limit, and bit 3 sets when it is at or above the critical limit, both compared as signed values.
- R6: Bits 1–3 stay set after the condition goes away, until software clears them.
- R7: A write to 0xA clears each of bits 1–3 written as 1 and loads bit 0 from the written value. A flag whose condition holds on the same clock as the clearing write stays set. A cleared flag sets again on the next sample that meets its condition. Bit 6 cannot be written.
- R8: A strobe with the open input high sets status bit 6, keeps the previous reading and sets no flag. The next strobe with the open input low clears bit 6 and is processed normally.
- R9: While standby is set, no channel accepts samples.
- R10: The alarm output is high exactly while bit 3 of at least one channel is set.
- R11: Offset 0xB returns the last accepted sample. Offsets outside 0x8–0xE read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| smp_strobe | input | 3 | Per-channel sample strobe |
| smp_temp | input | 24 | Per-channel signed sample, channel n in bits 8n+7:8n |
| smp_open | input | 3 | Per-channel open-sensor indication, qualified by the strobe |
| overtemp_alarm | output | 1 | High while any critical flag is set |

## Verification
The bench walks samples that sit exactly on each limit and one degree past it, so an off-by-one comparator shows up as a flag missing or set in the wrong place. Negative readings, -128 and +127 are included, which exposes an unsigned comparison that would raise the high flag for a cold reading. The bench also checks that flags survive a return to normal and that a clear issued on the same clock as a sample that still violates a limit loses to the set. It checks that an open-sensor sample leaves the reading unchanged, and that standby or a disabled channel blocks every update. Finally, it checks that the alarm pin follows the acknowledged flag rather than the live temperature.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

    typedef enum logic [1:0] {
        CH_DISABLED = 2'd0,
        CH_ACTIVE   = 2'd1,
        CH_OPEN     = 2'd2,
        CH_HALT     = 2'd3
    } ch_state_e;

    localparam int REG_AW = 4;
    localparam int STAT_W = 8;

    localparam logic [REG_AW-1:0] OFF_STANDBY = 4'h8;
    localparam logic [REG_AW-1:0] OFF_SELECT  = 4'h9;
    localparam logic [REG_AW-1:0] OFF_STATUS  = 4'hA;
    localparam logic [REG_AW-1:0] OFF_READING = 4'hB;
    localparam logic [REG_AW-1:0] OFF_HIGH    = 4'hC;
    localparam logic [REG_AW-1:0] OFF_LOW     = 4'hD;
    localparam logic [REG_AW-1:0] OFF_CRIT    = 4'hE;

    localparam int BIT_EN   = 0;
    localparam int BIT_LOW  = 1;
    localparam int BIT_HIGH = 2;
    localparam int BIT_CRIT = 3;
    localparam int BIT_OPEN = 6;

endpackage

// File: rtl/tmon_global.sv
module tmon_global
    import tmon_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DW     = 8,
    parameter int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic              standby,
    output logic [SEL_W-1:0]  sel
);

    logic             standby_q;
    logic [SEL_W-1:0] sel_q;
    logic             sel_ok;

    assign sel_ok = bus_wdata < DW'(NUM_CH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            standby_q <= 1'b0;
            sel_q     <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFF_STANDBY)
                standby_q <= bus_wdata[0];
            if (bus_addr == OFF_SELECT && sel_ok)
                sel_q <= bus_wdata[SEL_W-1:0];
        end
    end

    assign standby = standby_q;
    assign sel     = sel_q;

    // R2
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_SELECT && !sel_ok) |=> $stable(sel_q));

endmodule

// File: rtl/tmon_channel.sv
module tmon_channel
    import tmon_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              wr_stat,
    input  logic              wr_high,
    input  logic              wr_low,
    input  logic              wr_crit,
    input  logic [DW-1:0]     wdata,
    input  logic              smp_strobe,
    input  logic [DW-1:0]     smp_temp,
    input  logic              smp_open,
    output logic [STAT_W-1:0] status,
    output logic [DW-1:0]     reading,
    output logic [DW-1:0]     lim_high,
    output logic [DW-1:0]     lim_low,
    output logic [DW-1:0]     lim_crit,
    output logic              crit
);

    localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MAX_NEG = {1'b1, {(DW-1){1'b0}}};

    ch_state_e     state_q, state_d;
    logic          en_q, open_q;
    logic          flag_low_q, flag_high_q, flag_crit_q;
    logic [DW-1:0] reading_q, high_q, low_q, crit_q;
    logic          accept, clean;
    logic          hit_low, hit_high, hit_crit;
    logic          clr_low, clr_high, clr_crit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_DISABLED;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_DISABLED: begin
                if (standby)   state_d = CH_HALT;
                else if (en_q) state_d = open_q ? CH_OPEN : CH_ACTIVE;
            end
            CH_ACTIVE: begin
                if (standby)     state_d = CH_HALT;
                else if (!en_q)  state_d = CH_DISABLED;
                else if (open_q) state_d = CH_OPEN;
            end
            CH_OPEN: begin
                if (standby)      state_d = CH_HALT;
                else if (!en_q)   state_d = CH_DISABLED;
                else if (!open_q) state_d = CH_ACTIVE;
            end
            CH_HALT: begin
                if (!standby) begin
                    if (!en_q)       state_d = CH_DISABLED;
                    else if (open_q) state_d = CH_OPEN;
                    else             state_d = CH_ACTIVE;
                end
            end
            default: state_d = CH_DISABLED;
        endcase
    end

    // sample qualification and signed comparators
    assign accept   = smp_strobe && (state_q == CH_ACTIVE || state_q == CH_OPEN);
    assign clean    = accept && !smp_open;
    assign hit_low  = $signed(smp_temp) <= $signed(low_q);
    assign hit_high = $signed(smp_temp) >= $signed(high_q);
    assign hit_crit = $signed(smp_temp) >= $signed(crit_q);
    assign clr_low  = wr_stat && wdata[BIT_LOW];
    assign clr_high = wr_stat && wdata[BIT_HIGH];
    assign clr_crit = wr_stat && wdata[BIT_CRIT];

    // outputs and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            open_q      <= 1'b0;
            flag_low_q  <= 1'b0;
            flag_high_q <= 1'b0;
            flag_crit_q <= 1'b0;
            reading_q   <= '0;
            high_q      <= MAX_POS;
            low_q       <= MAX_NEG;
            crit_q      <= MAX_POS;
        end else begin
            if (wr_stat) en_q <= wdata[BIT_EN];
            if (accept)  open_q <= smp_open;
            if (clean)   reading_q <= smp_temp;
            flag_low_q  <= (flag_low_q  && !clr_low)  || (clean && hit_low);
            flag_high_q <= (flag_high_q && !clr_high) || (clean && hit_high);
            flag_crit_q <= (flag_crit_q && !clr_crit) || (clean && hit_crit);
            if (wr_high) high_q <= wdata;
            if (wr_low)  low_q  <= wdata;
            if (wr_crit) crit_q <= wdata;
        end
    end

    always_comb begin
        status           = '0;
        status[BIT_EN]   = en_q;
        status[BIT_LOW]  = flag_low_q;
        status[BIT_HIGH] = flag_high_q;
        status[BIT_CRIT] = flag_crit_q;
        status[BIT_OPEN] = open_q;
    end

    assign reading  = reading_q;
    assign lim_high = high_q;
    assign lim_low  = low_q;
    assign lim_crit = crit_q;
    assign crit     = flag_crit_q;

    // R3
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DISABLED) |=> ($stable(reading_q) && !$rose(flag_low_q)));

    // R9
    standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HALT) |=> ($stable(reading_q) && !$rose(flag_high_q)));

    // R8
    open_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_strobe && smp_open) |=> ($stable(reading_q) && !$rose(flag_crit_q)));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_high_q && !wr_stat) |=> flag_high_q);

    // R7
    clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_low && !smp_strobe) |=> !flag_low_q);

    // R5
    crit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_crit_q) |-> $past(smp_strobe));

endmodule

// File: rtl/tmon_thermal_monitor.sv
module tmon_thermal_monitor
    import tmon_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_AW-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NUM_CH-1:0]    smp_strobe,
    input  logic [NUM_CH*DW-1:0] smp_temp,
    input  logic [NUM_CH-1:0]    smp_open,
    output logic                 overtemp_alarm
);

    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic             standby;
    logic [SEL_W-1:0] sel;
    logic [STAT_W-1:0] status_a  [NUM_CH];
    logic [DW-1:0]     reading_a [NUM_CH];
    logic [DW-1:0]     high_a    [NUM_CH];
    logic [DW-1:0]     low_a     [NUM_CH];
    logic [DW-1:0]     crit_lim_a[NUM_CH];
    logic [NUM_CH-1:0] crit_v;

    tmon_global #(.NUM_CH(NUM_CH), .DW(DW), .SEL_W(SEL_W)) u_global (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .standby   (standby),
        .sel       (sel)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = bus_wr && (sel == SEL_W'(g));

        tmon_channel #(.DW(DW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .standby    (standby),
            .wr_stat    (hit && bus_addr == OFF_STATUS),
            .wr_high    (hit && bus_addr == OFF_HIGH),
            .wr_low     (hit && bus_addr == OFF_LOW),
            .wr_crit    (hit && bus_addr == OFF_CRIT),
            .wdata      (bus_wdata),
            .smp_strobe (smp_strobe[g]),
            .smp_temp   (smp_temp[g*DW +: DW]),
            .smp_open   (smp_open[g]),
            .status     (status_a[g]),
            .reading    (reading_a[g]),
            .lim_high   (high_a[g]),
            .lim_low    (low_a[g]),
            .lim_crit   (crit_lim_a[g]),
            .crit       (crit_v[g])
        );
    end

    always_comb begin
        logic [STAT_W-1:0] st;
        logic [DW-1:0]     rd, hi, lo, cr;
        st = '0; rd = '0; hi = '0; lo = '0; cr = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel == SEL_W'(i)) begin
                st = status_a[i];
                rd = reading_a[i];
                hi = high_a[i];
                lo = low_a[i];
                cr = crit_lim_a[i];
            end
        end
        unique case (bus_addr)
            OFF_STANDBY: bus_rdata = DW'(standby);
            OFF_SELECT:  bus_rdata = DW'(sel);
            OFF_STATUS:  bus_rdata = DW'(st);
            OFF_READING: bus_rdata = rd;
            OFF_HIGH:    bus_rdata = hi;
            OFF_LOW:     bus_rdata = lo;
            OFF_CRIT:    bus_rdata = cr;
            default:     bus_rdata = '0;
        endcase
    end

    assign overtemp_alarm = |crit_v;

    // R10
    alarm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overtemp_alarm) |-> $past(bus_wr && bus_addr == OFF_STATUS));

endmodule

// File: tb/tb_tmon_thermal_monitor.sv
module tb_tmon_thermal_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [2:0]  smp_strobe = '0;
    logic [23:0] smp_temp = '0;
    logic [2:0]  smp_open = '0;
    logic        overtemp_alarm;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmon_thermal_monitor dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_strobe(smp_strobe),
        .smp_temp(smp_temp), .smp_open(smp_open), .overtemp_alarm(overtemp_alarm)
    );

    // {temp, open, expected status, expected reading}; limits hi=40 lo=10 crit=60
    localparam logic [24:0] VEC [NV] = '{
        {8'h19, 1'b0, 8'h01, 8'h19},
        {8'h0A, 1'b0, 8'h03, 8'h0A},
        {8'h09, 1'b0, 8'h03, 8'h09},
        {8'h28, 1'b0, 8'h05, 8'h28},
        {8'h27, 1'b0, 8'h01, 8'h27},
        {8'h3C, 1'b0, 8'h0D, 8'h3C},
        {8'hEC, 1'b0, 8'h03, 8'hEC},
        {8'h64, 1'b1, 8'h41, 8'hEC},
        {8'h64, 1'b0, 8'h0D, 8'h64},
        {8'h80, 1'b0, 8'h03, 8'h80},
        {8'h7F, 1'b0, 8'h0D, 8'h7F},
        {8'h0B, 1'b0, 8'h01, 8'h0B}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic smp(input int ch, input logic [7:0] t, input logic op);
        @(negedge clk);
        smp_strobe[ch] = 1'b1;
        smp_temp[ch*8 +: 8] = t;
        smp_open[ch] = op;
        @(negedge clk);
        smp_strobe = '0;
        smp_open = '0;
    endtask

    task automatic rcheck(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rcheck("R1 standby", 4'h8, 8'h00);
        rcheck("R1 select", 4'h9, 8'h00);
        rcheck("R1 status", 4'hA, 8'h00);
        rcheck("R1 reading", 4'hB, 8'h00);
        rcheck("R1 high", 4'hC, 8'h7F);
        rcheck("R1 low", 4'hD, 8'h80);
        rcheck("R1 crit", 4'hE, 8'h7F);
        check("R1 alarm", {7'b0, overtemp_alarm}, 8'h00);

        // setup channel 0
        wr(4'hC, 8'h28);
        wr(4'hD, 8'h0A);
        wr(4'hE, 8'h3C);
        wr(4'hA, 8'h01);
        rcheck("R3 enable readback", 4'hA, 8'h01);

        // table walk: R4 R5 R8 R10 R11
        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            v = VEC[i];
            smp(0, v[24:17], v[16]);
            rcheck("R4/R5/R8 status", 4'hA, v[15:8]);
            rcheck("R11 reading", 4'hB, v[7:0]);
            check("R10 alarm", {7'b0, overtemp_alarm}, {7'b0, v[11]});
            wr(4'hA, 8'h0F);
        end

        // R6 sticky
        smp(0, 8'h46, 1'b0);
        smp(0, 8'h19, 1'b0);
        rcheck("R6 sticky", 4'hA, 8'h0D);
        check("R10 alarm held", {7'b0, overtemp_alarm}, 8'h01);
        wr(4'hA, 8'h0F);
        rcheck("R7 cleared", 4'hA, 8'h01);
        check("R10 alarm drop", {7'b0, overtemp_alarm}, 8'h00);

        // R7 re-arm
        smp(0, 8'h46, 1'b0);
        wr(4'hA, 8'h0F);
        rcheck("R7 clear without sample", 4'hA, 8'h01);
        smp(0, 8'h46, 1'b0);
        rcheck("R7 re-set", 4'hA, 8'h0D);

        // R7 same-cycle set wins
        @(negedge clk);
        bus_addr = 4'hA; bus_wdata = 8'h0F; bus_wr = 1'b1;
        smp_strobe[0] = 1'b1; smp_temp[7:0] = 8'h46;
        @(negedge clk);
        bus_wr = 1'b0; smp_strobe = '0;
        rcheck("R7 set wins", 4'hA, 8'h0D);

        // R7 partial clear
        smp(0, 8'h19, 1'b0);
        wr(4'hA, 8'h05);
        rcheck("R7 partial", 4'hA, 8'h09);
        wr(4'hA, 8'h0F);

        // R7 bit6 read-only
        wr(4'hA, 8'h41);
        rcheck("R7 open ro", 4'hA, 8'h01);

        // R9 standby
        wr(4'h8, 8'h01);
        rcheck("R9 standby readback", 4'h8, 8'h01);
        smp(0, 8'h46, 1'b0);
        rcheck("R9 reading frozen", 4'hB, 8'h19);
        rcheck("R9 status frozen", 4'hA, 8'h01);
        wr(4'h8, 8'h00);
        smp(0, 8'h1E, 1'b0);
        rcheck("R9 resume", 4'hB, 8'h1E);

        // R3 disabled channel 1, R2 banking
        wr(4'h9, 8'h01);
        rcheck("R2 select", 4'h9, 8'h01);
        smp(1, 8'h80, 1'b0);
        rcheck("R3 disabled status", 4'hA, 8'h00);
        rcheck("R3 disabled reading", 4'hB, 8'h00);
        rcheck("R2 bank high", 4'hC, 8'h7F);
        wr(4'hA, 8'h01);
        smp(1, 8'h80, 1'b0);
        rcheck("R4 low boundary", 4'hA, 8'h03);
        rcheck("R11 ch1 reading", 4'hB, 8'h80);
        wr(4'h9, 8'h03);
        rcheck("R2 invalid select", 4'h9, 8'h01);
        wr(4'hA, 8'h0F);

        // R10 alarm from channel 2
        wr(4'h9, 8'h02);
        wr(4'hA, 8'h01);
        wr(4'hE, 8'h00);
        smp(2, 8'h00, 1'b0);
        rcheck("R5 crit boundary", 4'hA, 8'h09);
        check("R10 ch2 alarm", {7'b0, overtemp_alarm}, 8'h01);
        wr(4'hA, 8'h0F);
        check("R10 ch2 alarm clear", {7'b0, overtemp_alarm}, 8'h00);

        // R11 unmapped
        rcheck("R11 unmapped read", 4'h3, 8'h00);
        wr(4'h3, 8'hFF);
        rcheck("R11 unmapped write", 4'h9, 8'h02);
        wr(4'h9, 8'h00);
        rcheck("R2 ch0 limit kept", 4'hC, 8'h28);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule